// File: doc/BRIEF.md
# Third-Order Sigma-Delta DAC Modulator with Mute Sequencing

This block turns signed 16-bit PCM samples into a single-bit oversampled stream for an audio DAC. It uses a chain of three saturating integrators with feedback, and it runs one step on every clock. The gain of each stage is a power of two, applied as an arithmetic right shift, so the loop needs no multipliers. A control bit picks one of two gain sets. A second control bit picks the size of a small resonator term that feeds the third integrator back into the second. A new PCM word is taken only when its valid strobe is high. The last captured word is used until the next strobe.

A mute request replaces the stream with an idle pattern of alternating ones and zeros, which averages to zero. When the bypass control is high, mute takes effect on the next output bit. When it is low, the block first drives the loop with a zero input and waits. It enters mute when all three integrators have stayed inside a small magnitude window for a run of consecutive cycles, or when a timeout expires, whichever comes first. While muted the loop state is held. Releasing mute resumes modulation from that held state.

Top module: `sdm3_dac`

## Requirements
- R1: After reset, `bitstream` and `mute_active` are both 0, and all control bits are taken as 0.
- R2: With both selects 0, the fraction of ones in `bitstream` tracks the held input as (FS + x) / 2FS. An output of 1 is fed back as +FS and 0 as −FS, where FS = 32768.
- R3: With `coef_sel` = 1, the stage gains are 1/16, 1/2 and 1/4 instead of 1/16, 1/4 and 1/2, and the ones density still follows R2.
- R4: With `lf_sel` = 1, the resonator gain is 1/4096 instead of 1/2048, and the ones density still follows R2.
- R5: A value on `pcm_in` while `pcm_valid` is 0 has no effect on the ones density. The previously captured sample stays in use.
- R6: With `settle_bypass` = 1, the first clock edge that sees `mute_req` high sets `mute_active` to 1 and `bitstream` to 1.
- R7: While `mute_active` is 1, `bitstream` inverts on every clock: 1, 0, 1, 0, and so on.
- R8: With `settle_bypass` = 0, mute is entered at the SETTLE_LEN-th edge after the edge that first saw the request, provided every integrator magnitude stays at or below QUIET_TH on each of those edges. The loop input is zero throughout this wait.
- R9: With `settle_bypass` = 0, if the quiet condition is never met, mute is entered at the TIMEOUT_CYC-th edge after the edge that first saw the request.
- R10: Any edge that sees `mute_req` low leaves `mute_active` at 0 after it, even the edge on which the settle wait would have completed.
- R11: The integrators are held while muted. After release, the bit sequence is the same as it would be had the mute lasted any other length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one output bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| pcm_in | input | IN_W | Signed PCM sample |
| pcm_valid | input | 1 | Capture strobe for `pcm_in` |
| mute_req | input | 1 | Mute request, level sensitive |
| settle_bypass | input | 1 | 1: mute at once; 0: wait for the loop to settle first |
| coef_sel | input | 1 | Stage gain set select |
| lf_sel | input | 1 | Resonator gain select |
| bitstream | output | 1 | Modulated single-bit output |
| mute_active | output | 1 | High while the mute pattern is being driven |

## Verification
The settle wait can finish on the same edge that sees the mute request withdrawn. The release must win, so the block returns to modulation instead of entering mute. The bench raises the request with a wide-threshold instance, where the wait ends after exactly SETTLE_LEN edges, and drops the request so that it is first seen on that final edge. It then expects `mute_active` to stay low on every following sample. A second overlap comes from two instances muted on the same edge and released at different times. Their post-release streams are compared bit for bit, which shows that the frozen state, and not the mute length, sets what comes next.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;
    typedef enum logic [1:0] {
        MS_RUN   = 2'd0,
        MS_WAIT  = 2'd1,
        MS_MUTED = 2'd2
    } mute_st_e;
endpackage

// File: rtl/sdm3_loop.sv
module sdm3_loop #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic signed [IN_W-1:0]  x_in,
    input  logic                    coef_sel,
    input  logic                    lf_sel,
    output logic signed [ACC_W-1:0] acc1_o,
    output logic signed [ACC_W-1:0] acc2_o,
    output logic signed [ACC_W-1:0] acc3_o,
    output logic                    q_o
);
    // working width leaves headroom for one sum before clamping
    localparam int SW = ACC_W + 2;
    localparam int G1_SH = 4;
    localparam logic signed [SW-1:0] FS =
        {{(SW-IN_W){1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
    localparam logic signed [SW-1:0] AMAX = {3'b000, {(ACC_W-1){1'b1}}};

    typedef struct packed {
        logic signed [ACC_W-1:0] a1;
        logic signed [ACC_W-1:0] a2;
        logic signed [ACC_W-1:0] a3;
    } loop_st_t;

    loop_st_t st_d, st_q;

    function automatic logic signed [ACC_W-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > AMAX)       return AMAX[ACC_W-1:0];
        else if (v < -AMAX) return -AMAX[ACC_W-1:0];
        else                return v[ACC_W-1:0];
    endfunction

    logic                   q;
    logic signed [SW-1:0]   fb, xe, e1, e2, e3, d1, d2, d3;
    int                     sh2, sh3, shl;

    always_comb begin
        q   = ~st_q.a3[ACC_W-1];
        fb  = q ? FS : -FS;
        xe  = {{(SW-IN_W){x_in[IN_W-1]}}, x_in};
        e1  = {{2{st_q.a1[ACC_W-1]}}, st_q.a1};
        e2  = {{2{st_q.a2[ACC_W-1]}}, st_q.a2};
        e3  = {{2{st_q.a3[ACC_W-1]}}, st_q.a3};
        sh2 = coef_sel ? 1 : 2;
        sh3 = coef_sel ? 2 : 1;
        shl = lf_sel ? 12 : 11;
        d1  = (xe - fb) >>> G1_SH;
        d2  = ((e1 - fb) >>> sh2) - (e3 >>> shl);
        d3  = (e2 - fb) >>> sh3;
        st_d = st_q;
        if (adv) begin
            st_d.a1 = clamp(e1 + d1);
            st_d.a2 = clamp(e2 + d2);
            st_d.a3 = clamp(e3 + d3);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc1_o = st_q.a1;
    assign acc2_o = st_q.a2;
    assign acc3_o = st_q.a3;
    assign q_o    = q;
endmodule

// File: rtl/sdm3_mute.sv
module sdm3_mute
    import sdm3_pkg::*;
#(
    parameter int ACC_W       = 24,
    parameter int SETTLE_LEN  = 256,
    parameter int QUIET_TH    = 64,
    parameter int TIMEOUT_CYC = 276480
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mute_req,
    input  logic                    bypass,
    input  logic signed [ACC_W-1:0] acc1,
    input  logic signed [ACC_W-1:0] acc2,
    input  logic signed [ACC_W-1:0] acc3,
    input  logic                    q_in,
    output logic                    adv_o,
    output logic                    zero_o,
    output logic                    bit_o,
    output logic                    active_o
);
    localparam int QW = $clog2(SETTLE_LEN + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [ACC_W:0] TH_V = (ACC_W+1)'(QUIET_TH);

    typedef struct packed {
        mute_st_e        st;
        logic [QW-1:0]   qc;
        logic [TW-1:0]   tc;
        logic            obit;
    } mctl_t;

    mctl_t r_d, r_q;

    function automatic logic [ACC_W:0] mag(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W:0] w;
        w = {a[ACC_W-1], a};
        return (w < 0) ? -w : w;
    endfunction

    logic quiet, go_mute;

    always_comb begin
        quiet   = (mag(acc1) <= TH_V) && (mag(acc2) <= TH_V) && (mag(acc3) <= TH_V);
        go_mute = 1'b0;
        r_d     = r_q;
        case (r_q.st)
            MS_RUN: begin
                if (mute_req) begin
                    if (bypass) go_mute = 1'b1;
                    else begin
                        r_d.st = MS_WAIT;
                        r_d.qc = '0;
                        r_d.tc = '0;
                    end
                end
            end
            MS_WAIT: begin
                if (!mute_req)  r_d.st = MS_RUN;
                else if (bypass) go_mute = 1'b1;
                else begin
                    r_d.tc = r_q.tc + 1'b1;
                    r_d.qc = quiet ? r_q.qc + 1'b1 : '0;
                    if ((quiet && r_q.qc == QW'(SETTLE_LEN - 1)) ||
                        r_q.tc == TW'(TIMEOUT_CYC - 1))
                        go_mute = 1'b1;
                end
            end
            MS_MUTED: begin
                if (!mute_req) r_d.st = MS_RUN;
            end
            default: r_d.st = MS_RUN;
        endcase
        if (go_mute) r_d.st = MS_MUTED;
        if (r_d.st == MS_MUTED)
            r_d.obit = (r_q.st == MS_MUTED) ? ~r_q.obit : 1'b1;
        else
            r_d.obit = q_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: MS_RUN, qc: '0, tc: '0, obit: 1'b0};
        else        r_q <= r_d;
    end

    assign adv_o    = (r_q.st != MS_MUTED);
    assign zero_o   = (r_q.st == MS_WAIT);
    assign active_o = (r_q.st == MS_MUTED);
    assign bit_o    = r_q.obit;
endmodule

// File: rtl/sdm3_dac.sv
module sdm3_dac #(
    parameter int IN_W        = 16,
    parameter int ACC_W       = 24,
    parameter int SETTLE_LEN  = 256,
    parameter int QUIET_TH    = 64,
    parameter int TIMEOUT_CYC = 276480
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] pcm_in,
    input  logic            pcm_valid,
    input  logic            mute_req,
    input  logic            settle_bypass,
    input  logic            coef_sel,
    input  logic            lf_sel,
    output logic            bitstream,
    output logic            mute_active
);
    typedef struct packed {
        logic signed [IN_W-1:0] pcm;
    } in_st_t;

    in_st_t in_d, in_q;

    logic                    adv_w, zero_w, q_w;
    logic signed [IN_W-1:0]  x_w;
    logic signed [ACC_W-1:0] acc1_w, acc2_w, acc3_w;

    always_comb begin
        in_d = in_q;
        if (pcm_valid) in_d.pcm = pcm_in;
        x_w = zero_w ? '0 : in_q.pcm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    sdm3_loop #(.IN_W(IN_W), .ACC_W(ACC_W)) loop_i (
        .clk(clk), .rst_n(rst_n), .adv(adv_w), .x_in(x_w),
        .coef_sel(coef_sel), .lf_sel(lf_sel),
        .acc1_o(acc1_w), .acc2_o(acc2_w), .acc3_o(acc3_w), .q_o(q_w)
    );

    sdm3_mute #(
        .ACC_W(ACC_W), .SETTLE_LEN(SETTLE_LEN),
        .QUIET_TH(QUIET_TH), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) mute_i (
        .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .bypass(settle_bypass),
        .acc1(acc1_w), .acc2(acc2_w), .acc3(acc3_w), .q_in(q_w),
        .adv_o(adv_w), .zero_o(zero_w), .bit_o(bitstream), .active_o(mute_active)
    );
endmodule

// File: rtl/sdm3_dac_chk.sv
module sdm3_dac_chk #(
    parameter int ACC_W       = 24,
    parameter int TIMEOUT_CYC = 276480
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mute_req,
    input logic                    settle_bypass,
    input logic                    bitstream,
    input logic                    mute_active,
    input logic signed [ACC_W-1:0] acc1
);
    int wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_cnt <= 0;
        else        wait_cnt <= (mute_req && !mute_active) ? wait_cnt + 1 : 0;
    end

    // R6
    fast_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settle_bypass && mute_req && !mute_active |=> mute_active && bitstream);

    // R7
    pattern_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_active && $past(mute_active) |-> bitstream != $past(bitstream));

    // R7
    pattern_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_active) |-> bitstream);

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_req |=> !mute_active);

    // R11
    frozen_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_active |=> $stable(acc1));

    // R9
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= TIMEOUT_CYC + 1);
endmodule

bind sdm3_dac sdm3_dac_chk #(.ACC_W(ACC_W), .TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .settle_bypass(settle_bypass),
    .bitstream(bitstream), .mute_active(mute_active), .acc1(acc1_w)
);

// File: tb/sdm3_dac_test.sv
module sdm3_dac_test;
    localparam int IN_W = 16;
    localparam int TMO  = 1000;
    localparam int SLEN = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IN_W-1:0] pcm_in = '0;
    logic pcm_valid = 1'b0, mute_a = 1'b0, mute_b = 1'b0;
    logic bypass = 1'b0, coef_sel = 1'b0, lf_sel = 1'b0;
    logic bit_a, act_a, bit_b, act_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdm3_dac #(.SETTLE_LEN(SLEN), .QUIET_TH(0), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .pcm_in(pcm_in), .pcm_valid(pcm_valid),
        .mute_req(mute_a), .settle_bypass(bypass), .coef_sel(coef_sel),
        .lf_sel(lf_sel), .bitstream(bit_a), .mute_active(act_a)
    );

    sdm3_dac #(.SETTLE_LEN(SLEN), .QUIET_TH(8388607), .TIMEOUT_CYC(TMO)) uut_q (
        .clk(clk), .rst_n(rst_n), .pcm_in(pcm_in), .pcm_valid(pcm_valid),
        .mute_req(mute_b), .settle_bypass(bypass), .coef_sel(coef_sel),
        .lf_sel(lf_sel), .bitstream(bit_b), .mute_active(act_b)
    );

    typedef struct {
        int    inst;
        bit    chk_bit;
        bit    exp_bit;
        bit    exp_act;
        string req;
    } exp_t;

    exp_t exp_q[$];

    task automatic push(int inst, bit cb, bit b, bit a, string req, int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.inst = inst; e.chk_bit = cb; e.exp_bit = b; e.exp_act = a; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    // monitor: one expected item per falling edge
    always @(negedge clk) begin
        exp_t e;
        logic ab, aa;
        if (exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            ab = (e.inst == 0) ? bit_a : bit_b;
            aa = (e.inst == 0) ? act_a : act_b;
            total++;
            if (aa !== e.exp_act || (e.chk_bit && ab !== e.exp_bit)) begin
                bad++;
                $display("FAIL %s inst=%0d act=%b/%b expected act=%b/%b",
                         e.req, e.inst, aa, ab, e.exp_act, e.exp_bit);
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int lo, int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic set_pcm(int v);
        @(posedge clk); #1;
        pcm_in = IN_W'(v);
        pcm_valid = 1'b1;
        @(posedge clk); #1;
        pcm_valid = 1'b0;
    endtask

    task automatic density(string req, int exp_ones);
        int ones = 0;
        repeat (1024) @(negedge clk);
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            ones += int'(bit_a);
        end
        check(req, ones, exp_ones - 205, exp_ones + 205);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset outputs
        check("R1 bit_a", int'(bit_a), 0, 0);
        check("R1 act_a", int'(act_a), 0, 0);
        check("R1 bit_b", int'(bit_b), 0, 0);
        check("R1 act_b", int'(act_b), 0, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2: density follows input
        set_pcm(8192);
        density("R2 +FS/4", 2560);
        set_pcm(-8192);
        density("R2 -FS/4", 1536);

        // R5: unstrobed word ignored
        @(posedge clk); #1 pcm_in = IN_W'(8192);
        density("R5 no strobe", 1536);

        // R3 and R4: other gain selections
        coef_sel = 1'b1;
        set_pcm(8192);
        density("R3 coef set 1", 2560);
        coef_sel = 1'b0; lf_sel = 1'b1;
        density("R4 lf 1/4096", 2560);
        coef_sel = 1'b1;
        set_pcm(-8192);
        density("R3 R4 both set", 1536);
        coef_sel = 1'b0; lf_sel = 1'b0;

        // R6, R7: immediate mute and pattern
        bypass = 1'b1;
        @(posedge clk); #1 mute_a = 1'b1;
        @(negedge clk); #1;
        push(0, 1, 1, 1, "R6", 1);
        for (int k = 0; k < 7; k++) push(0, 1, k[0] ? 1'b1 : 1'b0, 1, "R7", 1);
        drain();
        @(posedge clk); #1 mute_a = 1'b0;
        @(negedge clk); #1;
        push(0, 0, 0, 0, "R10 release", 3);
        drain();

        // R11: resume from held state, independent of mute length
        do_reset();
        set_pcm(8192);
        repeat (300) @(posedge clk);
        #1 mute_a = 1'b1; mute_b = 1'b1;
        begin
            bit ra[64];
            bit rb[64];
            int mism = 0;
            repeat (5) @(posedge clk);
            #1 mute_a = 1'b0;
            fork
                begin
                    for (int i = 0; i < 64; i++) begin
                        @(negedge clk);
                        ra[i] = bit_a;
                    end
                end
                begin
                    repeat (15) @(posedge clk);
                    #1 mute_b = 1'b0;
                    for (int i = 0; i < 64; i++) begin
                        @(negedge clk);
                        rb[i] = bit_b;
                    end
                end
            join
            for (int i = 1; i < 64; i++) if (ra[i] != rb[i]) mism++;
            check("R11 resume mismatches", mism, 0, 0);
        end

        // R9: timeout path (quiet never met on uut)
        bypass = 1'b0;
        @(posedge clk); #1 mute_a = 1'b1;
        @(negedge clk); #1;
        push(0, 0, 0, 0, "R9 waiting", TMO);
        push(0, 1, 1, 1, "R9 entry", 1);
        push(0, 1, 0, 1, "R9 pattern", 1);
        drain();
        @(posedge clk); #1 mute_a = 1'b0;
        @(negedge clk); #1;
        push(0, 0, 0, 0, "R10 release", 2);
        drain();

        // R8: quiet path on uut_q
        @(posedge clk); #1 mute_b = 1'b1;
        @(negedge clk); #1;
        push(1, 0, 0, 0, "R8 waiting", SLEN);
        push(1, 1, 1, 1, "R8 entry", 1);
        push(1, 1, 0, 1, "R8 pattern", 1);
        drain();
        @(posedge clk); #1 mute_b = 1'b0;
        @(negedge clk); #1;
        push(1, 0, 0, 0, "R10 release", 2);
        drain();

        // R10: release seen on the edge that would finish the wait
        @(posedge clk); #1 mute_b = 1'b1;
        repeat (SLEN) @(posedge clk);
        #1 mute_b = 1'b0;
        @(negedge clk); #1;
        push(1, 0, 0, 0, "R10 release beats settle", 6);
        drain();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule